// File: doc/BRIEF.md
# Card Socket Interrupt Event Controller

This block collects the interrupt events of a single card socket and turns them into two host interrupt lines. The first line, `csc_irq`, reports status-change events. These include card-side signal changes arriving as one-cycle strobes, and a power-cycle-complete event. The block raises the power event itself when the socket's powered indication goes from low to high. The second line, `func_irq`, passes through the card's own functional interrupt. That interrupt has no mask and is blocked whenever the socket is not powered.

Every status-change event sets a sticky flag in two flag banks at once. The legacy bank serves a 16-bit software view. The socket bank serves a 32-bit software view. Each bank has its own enable mask, and a mask bit of 1 enables its source.

The two banks clear their flags in different ways. The socket bank always clears by write-one-to-clear. In the legacy bank, software chooses the clearing style at run time with bit 2 of the global control register: 0 selects clear-on-read, 1 selects write-one-to-clear. Software reaches all of this through a small register port whose read data is registered.

Top module: `sock_irq_ctrl`

## Requirements
- R1: When `ev_stb[i]` is high at a clock edge, flag bit i is set in both the legacy flag register (address 1) and the socket flag register (address 3), and is readable one clock later. A set flag stays set until it is cleared.
- R2: When `sock_powered` goes from 0 to 1, flag bit 4 (power cycle complete) is set once in both banks. Holding `sock_powered` high does not set it again.
- R3: `csc_irq` is high one clock after any flag in either bank is set while its mask bit is 1. The masks are at address 2 (legacy) and address 4 (socket). `csc_irq` stays high until every enabled flag is cleared.
- R4: A flag whose mask bit is 0 can still be read, but it does not raise `csc_irq`.
- R5: When global control bit 2 is 0, reading address 1 returns the flag values held before the read and then clears all legacy flags. In this mode a write to address 1 has no effect.
- R6: When global control bit 2 is 1, writing 1 to a legacy flag bit clears it, writing 0 leaves it unchanged, and reading does not clear it.
- R7: Socket flags clear only when 1 is written to the bit at address 3. A read of address 3 never clears them, whatever the value of global control bit 2.
- R8: If an event sets a flag in the same cycle that a read or a write clears it, the flag stays set.
- R9: `func_irq` follows `card_irq` one clock later, but only while `sock_powered` is 1. No mask applies to it. Status register address 5 reports it in bit 0 and reports the powered state in bit 1.
- R10: After reset, all flags, masks and global control bit 2 are 0, and `csc_irq`, `func_irq` and `rdata` are 0.
- R11: `rdata` is loaded from the register at `addr` on the clock edge where `rd_en` is high, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_stb | input | N_EV | One-cycle card-side event strobes |
| sock_powered | input | 1 | Socket power is up |
| card_irq | input | 1 | Functional interrupt level from the card |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| csc_irq | output | 1 | Status-change interrupt level |
| func_irq | output | 1 | Functional card interrupt level |

## Verification
The hardest cases to reach are collisions between a clear and a new event for the same flag. One is a clear-on-read of the legacy bank in the same cycle as an event strobe. The other is a write-one-to-clear of the socket bank in that same kind of cycle. The directed tasks drive the strobe and the bus access on the same falling edge, so both land on one rising edge. The task then checks two things: the read returned the old value, and a second read still shows the flag. The one-shot power flag is reached by raising `sock_powered`, clearing the flag, and then confirming that it stays clear while power remains up.

// File: rtl/sie_pkg.sv
package sie_pkg;
  localparam int ADDR_W   = 3;
  localparam int MODE_BIT = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_GCTL  = 3'd0,
    RA_LFLAG = 3'd1,
    RA_LMASK = 3'd2,
    RA_SFLAG = 3'd3,
    RA_SMASK = 3'd4,
    RA_STAT  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/sie_flag_bank.sv
module sie_flag_bank #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  input  logic          mask_we,
  input  logic [NF-1:0] mask_d,
  output logic [NF-1:0] flag_o,
  output logic [NF-1:0] mask_o,
  output logic          pend_o
);
  logic [NF-1:0] flag_q;
  logic [NF-1:0] mask_q;

  for (genvar b = 0; b < NF; b++) begin : g_bit
    // set takes priority over clear on the same edge
    always_ff @(posedge clk) begin
      if (rst)           flag_q[b] <= 1'b0;
      else if (set_i[b]) flag_q[b] <= 1'b1;
      else if (clr_i[b]) flag_q[b] <= 1'b0;
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
      set_i[b] |=> flag_q[b]); // R8
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
      (clr_i[b] && !set_i[b]) |=> !flag_q[b]); // R6
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
      (!set_i[b] && !flag_q[b]) |=> !flag_q[b]); // R1
  end

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (mask_we) mask_q <= mask_d;
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;
  assign pend_o = |(flag_q & mask_q);
endmodule

// File: rtl/sie_sock_mon.sv
module sie_sock_mon (
  input  logic clk,
  input  logic rst,
  input  logic sock_powered,
  input  logic card_irq,
  output logic pwr_evt_o,
  output logic powered_o,
  output logic func_o
);
  logic powered_q;
  logic func_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      powered_q <= 1'b0;
      func_q    <= 1'b0;
    end else begin
      powered_q <= sock_powered;
      func_q    <= card_irq & sock_powered;
    end
  end

  assign pwr_evt_o = sock_powered & ~powered_q;
  assign powered_o = powered_q;
  assign func_o    = func_q;

  AST_FUNC_GATED: assert property (@(posedge clk) disable iff (rst)
    !sock_powered |=> !func_q); // R9
  AST_PWR_ONCE: assert property (@(posedge clk) disable iff (rst)
    pwr_evt_o |=> !pwr_evt_o); // R2
endmodule

// File: rtl/sie_rd_port.sv
module sie_rd_port
  import sie_pkg::*;
#(
  parameter int NF     = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mode_w1c,
  input  logic [NF-1:0]     l_flag,
  input  logic [NF-1:0]     l_mask,
  input  logic [NF-1:0]     s_flag,
  input  logic [NF-1:0]     s_mask,
  input  logic              func,
  input  logic              powered,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD = DATA_W - NF;

  logic [DATA_W-1:0] mux_d;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    mux_d = '0;
    case (reg_addr_e'(addr))
      RA_GCTL:  mux_d[MODE_BIT] = mode_w1c;
      RA_LFLAG: mux_d = {{PAD{1'b0}}, l_flag};
      RA_LMASK: mux_d = {{PAD{1'b0}}, l_mask};
      RA_SFLAG: mux_d = {{PAD{1'b0}}, s_flag};
      RA_SMASK: mux_d = {{PAD{1'b0}}, s_mask};
      RA_STAT:  mux_d[1:0] = {powered, func};
      default:  mux_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= mux_d;
  end

  assign rdata = rdata_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata_q)); // R11
endmodule

// File: rtl/sock_irq_ctrl.sv
module sock_irq_ctrl
  import sie_pkg::*;
#(
  parameter int N_EV   = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EV-1:0]   ev_stb,
  input  logic              sock_powered,
  input  logic              card_irq,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              csc_irq,
  output logic              func_irq
);
  localparam int NF = N_EV + 1;

  logic          mode_w1c;
  logic          pwr_evt;
  logic          powered;
  logic          func;
  logic [NF-1:0] ev_all;
  logic [NF-1:0] l_clr;
  logic [NF-1:0] s_clr;
  logic [NF-1:0] l_flag;
  logic [NF-1:0] l_mask;
  logic [NF-1:0] s_flag;
  logic [NF-1:0] s_mask;
  logic          l_pend;
  logic          s_pend;
  logic          csc_q;
  logic          l_rd_hit;
  logic          l_wr_hit;
  logic          s_wr_hit;

  assign ev_all   = {pwr_evt, ev_stb};
  assign l_rd_hit = rd_en && (reg_addr_e'(addr) == RA_LFLAG);
  assign l_wr_hit = wr_en && (reg_addr_e'(addr) == RA_LFLAG);
  assign s_wr_hit = wr_en && (reg_addr_e'(addr) == RA_SFLAG);

  always_comb begin
    if (mode_w1c) l_clr = l_wr_hit ? wdata[NF-1:0] : '0;
    else          l_clr = l_rd_hit ? '1 : '0;
  end
  assign s_clr = s_wr_hit ? wdata[NF-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) mode_w1c <= 1'b0;
    else if (wr_en && reg_addr_e'(addr) == RA_GCTL) mode_w1c <= wdata[MODE_BIT];
  end

  sie_sock_mon i_mon (
    .clk          (clk),
    .rst          (rst),
    .sock_powered (sock_powered),
    .card_irq     (card_irq),
    .pwr_evt_o    (pwr_evt),
    .powered_o    (powered),
    .func_o       (func)
  );

  sie_flag_bank #(.NF(NF)) i_lbank (
    .clk     (clk),
    .rst     (rst),
    .set_i   (ev_all),
    .clr_i   (l_clr),
    .mask_we (wr_en && reg_addr_e'(addr) == RA_LMASK),
    .mask_d  (wdata[NF-1:0]),
    .flag_o  (l_flag),
    .mask_o  (l_mask),
    .pend_o  (l_pend)
  );

  sie_flag_bank #(.NF(NF)) i_sbank (
    .clk     (clk),
    .rst     (rst),
    .set_i   (ev_all),
    .clr_i   (s_clr),
    .mask_we (wr_en && reg_addr_e'(addr) == RA_SMASK),
    .mask_d  (wdata[NF-1:0]),
    .flag_o  (s_flag),
    .mask_o  (s_mask),
    .pend_o  (s_pend)
  );

  sie_rd_port #(.NF(NF), .DATA_W(DATA_W)) i_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .addr     (addr),
    .mode_w1c (mode_w1c),
    .l_flag   (l_flag),
    .l_mask   (l_mask),
    .s_flag   (s_flag),
    .s_mask   (s_mask),
    .func     (func),
    .powered  (powered),
    .rdata    (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) csc_q <= 1'b0;
    else     csc_q <= l_pend | s_pend;
  end

  assign csc_irq  = csc_q;
  assign func_irq = func;

  AST_CSC_RAISE: assert property (@(posedge clk) disable iff (rst)
    (|(l_flag & l_mask) || |(s_flag & s_mask)) |=> csc_irq); // R3
  AST_CSC_IDLE: assert property (@(posedge clk) disable iff (rst)
    (l_flag & l_mask) == '0 && (s_flag & s_mask) == '0 |=> !csc_irq); // R4
  AST_COR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (l_rd_hit && !mode_w1c && ev_all == '0) |=> l_flag == '0); // R5
  AST_SREAD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!s_wr_hit) |=> ($past(s_flag) & ~s_flag) == '0); // R7
endmodule

// File: tb/test_sock_irq_ctrl.sv
module test_sock_irq_ctrl;
  localparam int N_EV   = 4;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [N_EV-1:0]   ev_stb = '0;
  logic              sock_powered = 1'b0;
  logic              card_irq = 1'b0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [2:0]        addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              csc_irq;
  logic              func_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  sock_irq_ctrl #(.N_EV(N_EV), .DATA_W(DATA_W)) i_sock_irq_ctrl (
    .clk(clk), .rst(rst), .ev_stb(ev_stb), .sock_powered(sock_powered),
    .card_irq(card_irq), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .csc_irq(csc_irq), .func_irq(func_irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(input logic [N_EV-1:0] e);
    @(negedge clk); ev_stb = e;
    @(negedge clk); ev_stb = '0;
  endtask

  task automatic clear_all();
    wr(3'd0, 8'h04);
    wr(3'd1, 8'h1F);
    wr(3'd3, 8'h1F);
    wr(3'd0, 8'h00);
  endtask

  task automatic test_reset();
    logic [7:0] d;
    chk("R10 csc", csc_irq, 0);
    chk("R10 func", func_irq, 0);
    chk("R10 rdata", rdata, 0);
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], d);
      chk("R10 reg", d, 0);
    end
  endtask

  task automatic test_set_sticky();
    logic [7:0] d;
    pulse(4'b0101);
    repeat (3) @(negedge clk);
    rd(3'd3, d); chk("R1 socket flags sticky", d, 8'h05);
    rd(3'd3, d); chk("R7 socket read keeps", d, 8'h05);
    chk("R4 masked no csc", csc_irq, 0);
    rd(3'd1, d); chk("R1 legacy flags", d, 8'h05);
    rd(3'd1, d); chk("R5 cleared by read", d, 8'h00);
    wr(3'd3, 8'h05);
    rd(3'd3, d); chk("R7 socket w1c", d, 8'h00);
  endtask

  task automatic test_mask_csc();
    logic [7:0] d;
    wr(3'd2, 8'h02);
    pulse(4'b0001);
    @(negedge clk);
    chk("R4 unmasked bit0 no csc", csc_irq, 0);
    pulse(4'b0010);
    chk("R3 csc not yet", csc_irq, 0);
    @(negedge clk);
    chk("R3 csc asserted", csc_irq, 1);
    wr(3'd3, 8'h03);
    repeat (2) @(negedge clk);
    chk("R3 socket clear alone keeps csc", csc_irq, 1);
    rd(3'd1, d); chk("R5 read returns pre-clear", d, 8'h03);
    @(negedge clk);
    chk("R3 csc dropped", csc_irq, 0);
    wr(3'd2, 8'h00);
    wr(3'd4, 8'h08);
    pulse(4'b1000);
    @(negedge clk);
    chk("R3 socket mask raises csc", csc_irq, 1);
    clear_all();
    @(negedge clk);
    chk("R3 csc after clear", csc_irq, 0);
    wr(3'd4, 8'h00);
  endtask

  task automatic test_cor_write_ignored();
    logic [7:0] d;
    pulse(4'b0100);
    wr(3'd1, 8'h1F);
    rd(3'd1, d); chk("R5 write ignored in read-clear mode", d, 8'h04);
    wr(3'd3, 8'h1F);
  endtask

  task automatic test_w1c_legacy();
    logic [7:0] d;
    wr(3'd0, 8'h04);
    rd(3'd0, d); chk("R6 mode bit readback", d, 8'h04);
    pulse(4'b0011);
    rd(3'd1, d); chk("R6 read keeps", d, 8'h03);
    wr(3'd1, 8'h00);
    rd(3'd1, d); chk("R6 write zero no effect", d, 8'h03);
    wr(3'd1, 8'h01);
    rd(3'd1, d); chk("R6 write one clears bit", d, 8'h02);
    rd(3'd3, d); chk("R7 socket read in w1c mode", d, 8'h03);
    clear_all();
  endtask

  task automatic test_collision();
    logic [7:0] d;
    pulse(4'b0001);
    @(negedge clk); ev_stb = 4'b0001; rd_en = 1'b1; addr = 3'd1;
    @(negedge clk); ev_stb = '0; rd_en = 1'b0; d = rdata;
    chk("R8 read returns old", d, 8'h01);
    rd(3'd1, d); chk("R8 set beats read clear", d, 8'h01);
    @(negedge clk); ev_stb = 4'b0001; wr_en = 1'b1; addr = 3'd3; wdata = 8'h01;
    @(negedge clk); ev_stb = '0; wr_en = 1'b0;
    rd(3'd3, d); chk("R8 set beats w1c", d, 8'h01);
    clear_all();
  endtask

  task automatic test_power_func();
    logic [7:0] d;
    card_irq = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 unpowered ignored", func_irq, 0);
    rd(3'd5, d); chk("R9 status unpowered", d, 0);
    @(negedge clk); sock_powered = 1'b1;
    @(negedge clk);
    chk("R9 func follows", func_irq, 1);
    rd(3'd3, d); chk("R2 power flag set", d, 8'h10);
    rd(3'd5, d); chk("R9 status powered", d, 8'h03);
    wr(3'd3, 8'h10);
    repeat (3) @(negedge clk);
    rd(3'd3, d); chk("R2 no repeat while powered", d, 8'h00);
    rd(3'd1, d); chk("R2 legacy power flag", d, 8'h10);
    @(negedge clk); card_irq = 1'b0;
    @(negedge clk);
    chk("R9 func drops", func_irq, 0);
    card_irq = 1'b1;
    @(negedge clk); sock_powered = 1'b0;
    @(negedge clk);
    chk("R9 power loss gates", func_irq, 0);
    card_irq = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_set_sticky();
    test_mask_csc();
    test_cor_write_ignored();
    test_w1c_legacy();
    test_collision();
    test_power_func();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule